// File: doc/BRIEF.md
# Buffered Transmit Serializer with Byte Counter

This block is the transmit datapath of a packet radio. A host pushes bytes into a four-entry buffer. The block sends them out one bit at a time, most significant bit first, on a single modulator data line. Each bit is either Manchester coded or sent as plain NRZ, and the bit rate is picked from four settings derived from a half-bit tick. Selecting transmit mode first puts the block in a start-up state. Bits are only sent after the PLL reports lock. Sending then begins on its own as soon as a byte is waiting.

The host reads a byte counter that rises on each accepted byte and falls when a byte has been fully sent. A one-cycle interrupt pulse fires when a net decrement lands the counter on a programmable threshold. The same event sets a sticky status bit. In transparent mode the buffer is switched off and the output simply follows an external serial bit. Any configuration write clears the buffer, the counter, the shifter and the error flags. It also latches the new settings, including the ASK/FSK selection that is driven to the modulator.

Top module: `byte_tx_serializer`

## Requirements
- R1: After synchronous reset, tx_bit, mod_ask, irq_pulse, irq_status, overflow and underrun are 0 and byte_count is 0.
- R2: When tx_en rises the block waits in start-up. No bit is sent (tx_bit stays 0) until pll_lock is seen high. The first buffered byte is loaded one clock after the active state is entered.
- R3: Bytes go out MSB first. With pattern mode off, a 1 is sent as a high half-bit followed by a low half-bit, and a 0 as low then high.
- R4: With pattern mode on (cfg_pattern=1), both half-bits of a bit carry the bit value (NRZ).
- R5: Each half-bit lasts 2^cfg_rate tick pulses, for cfg_rate 0 to 3.
- R6: byte_count rises by one per accepted write and falls by one when the last half-bit of a byte ends. Consecutive buffered bytes are sent with no gap.
- R7: irq_pulse is high for one cycle when a net decrement leaves byte_count equal to cfg_thr. irq_status then stays set until a cycle with irq_clr high.
- R8: A write into a full buffer (4 bytes held) is dropped, leaves byte_count unchanged and sets the sticky overflow flag.
- R9: When a byte ends with the buffer empty, tx_bit returns to 0 and the sticky underrun flag is set.
- R10: With cfg_transp=1, tx_bit equals ext_bit of the previous cycle and byte writes are ignored (byte_count stays 0).
- R11: A cfg_wr pulse latches all cfg_* fields, aborts the byte in flight (tx_bit 0), and clears the buffer, byte_count, overflow and underrun. mod_ask shows the latched cfg_ask.
- R12: Writes while tx_en is low are ignored, and dropping tx_en clears the buffer and byte_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit mode select |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rate | input | 2 | Bit-rate select, half-bit = 2^value ticks |
| cfg_ask | input | 1 | 1 = ASK, 0 = FSK |
| cfg_pattern | input | 1 | 1 = NRZ, 0 = Manchester |
| cfg_transp | input | 1 | Transparent bypass enable |
| cfg_thr | input | 2 | Interrupt threshold for the byte counter |
| pll_lock | input | 1 | PLL lock flag |
| tick | input | 1 | Half-bit base rate enable |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to buffer |
| ext_bit | input | 1 | External serial bit for transparent mode |
| irq_clr | input | 1 | Write-one-to-clear of irq_status |
| tx_bit | output | 1 | Modulator data bit |
| mod_ask | output | 1 | Latched modulation type |
| irq_pulse | output | 1 | Threshold interrupt pulse |
| irq_status | output | 1 | Sticky interrupt status |
| byte_count | output | 3 | Bytes buffered or in flight |
| overflow | output | 1 | Sticky dropped-write flag |
| underrun | output | 1 | Sticky empty-buffer flag |

## Verification
The hardest case to reach from the ports is the exact cycle where a byte finishes. At that edge the counter drops, the threshold pulse may fire, the next byte loads with no gap, or the line idles and sets underrun. Each packet is therefore loaded fully during start-up. The bench then releases pll_lock at a known edge and holds tick high. This makes every half-bit boundary predictable, so the bench can sample the line, the counter and the pulse at each byte end. Random byte values, rates, coding modes and thresholds are mixed with directed packets that hit threshold 0, a threshold that is never reached, a full buffer and an abort in mid-byte.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int RATE_W = 2;
  localparam int THR_W  = 2;

  typedef enum logic [1:0] {ST_OFF, ST_START, ST_ACTIVE} tx_state_e;

  typedef struct packed {
    logic              pattern;
    logic              transp;
    logic              ask;
    logic [THR_W-1:0]  thr;
    logic [RATE_W-1:0] rate;
  } tx_cfg_t;
endpackage

// File: rtl/txs_fifo.sv
module txs_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0] wp, rp;

  always_ff @(posedge clk) begin
    if (wr) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (rd) rp <= rp + 1'b1;
    end
  end

  assign rdata = mem[rp[AW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);

  p_no_write_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    wr |-> !full);
  p_no_read_when_empty_r9: assert property (@(posedge clk) disable iff (rst)
    rd |-> !empty);
endmodule

// File: rtl/txs_rate_gen.sv
module txs_rate_gen #(
  parameter int RATE_W = 2,
  localparam int PRE_W = (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              hb_en
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < PRE_W; i++) lim[i] = (i < int'(rate));
  end

  assign hb_en = tick && (pre == lim);

  always_ff @(posedge clk) begin
    if (rst || clear) pre <= '0;
    else if (tick)    pre <= hb_en ? '0 : pre + 1'b1;
  end

  p_prescale_bound_r5: assert property (@(posedge clk) disable iff (rst)
    pre <= lim || $past(rate) != rate);
endmodule

// File: rtl/txs_shifter.sv
module txs_shifter #(
  parameter int DATA_W = 8,
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              hb_en,
  input  logic              pattern,
  output logic              busy,
  output logic              done,
  output logic              enc_nxt
);
  logic [DATA_W-1:0] sh, sh_n;
  logic [IW-1:0]     idx, idx_n;
  logic              ph, ph_n, busy_n;

  assign done = busy && hb_en && ph && (idx == '0);

  always_comb begin
    sh_n = sh; idx_n = idx; ph_n = ph; busy_n = busy;
    if (flush) begin
      busy_n = 1'b0;
    end else if (load) begin
      sh_n = din; idx_n = IW'(DATA_W - 1); ph_n = 1'b0; busy_n = 1'b1;
    end else if (busy && hb_en) begin
      if (!ph) begin
        ph_n = 1'b1;
      end else if (idx == '0) begin
        busy_n = 1'b0;
      end else begin
        idx_n = idx - 1'b1;
        ph_n  = 1'b0;
        sh_n  = sh << 1;
      end
    end
    if (!busy_n)   enc_nxt = 1'b0;
    else if (!ph_n) enc_nxt = sh_n[DATA_W-1];
    else           enc_nxt = pattern ? sh_n[DATA_W-1] : ~sh_n[DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; idx <= '0; ph <= 1'b0; busy <= 1'b0;
    end else begin
      sh <= sh_n; idx <= idx_n; ph <= ph_n; busy <= busy_n;
    end
  end

  p_end_on_halfbit_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(flush)) |-> $past(hb_en));
  p_load_idle_r6: assert property (@(posedge clk) disable iff (rst)
    load |-> (!busy || done));
endmodule

// File: rtl/byte_tx_serializer.sv
module byte_tx_serializer #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 2),
  localparam int RW    = txs_pkg::RATE_W,
  localparam int TW    = txs_pkg::THR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              cfg_wr,
  input  logic [RW-1:0]     cfg_rate,
  input  logic              cfg_ask,
  input  logic              cfg_pattern,
  input  logic              cfg_transp,
  input  logic [TW-1:0]     cfg_thr,
  input  logic              pll_lock,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_bit,
  input  logic              irq_clr,
  output logic              tx_bit,
  output logic              mod_ask,
  output logic              irq_pulse,
  output logic              irq_status,
  output logic [CNT_W-1:0]  byte_count,
  output logic              overflow,
  output logic              underrun
);
  import txs_pkg::*;

  tx_state_e         state;
  tx_cfg_t           cfg_q;
  logic              flush, wr_try, wr_acc, load, hb_en;
  logic              f_full, f_empty, busy, done, enc_nxt;
  logic [DATA_W-1:0] f_rdata;

  assign flush  = cfg_wr || !tx_en;
  assign wr_try = wr_en && (state != ST_OFF) && !cfg_q.transp && !flush;
  assign wr_acc = wr_try && !f_full;
  assign load   = (state == ST_ACTIVE) && !cfg_q.transp && !flush &&
                  !f_empty && (!busy || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OFF;
    end else begin
      case (state)
        ST_OFF:    if (tx_en) state <= ST_START;
        ST_START:  if (!tx_en) state <= ST_OFF; else if (pll_lock) state <= ST_ACTIVE;
        default:   if (!tx_en) state <= ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= '{pattern: cfg_pattern, transp: cfg_transp,
                                ask: cfg_ask, thr: cfg_thr, rate: cfg_rate};
  end
  assign mod_ask = cfg_q.ask;

  txs_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .wr(wr_acc), .wdata(wr_data),
    .rd(load), .rdata(f_rdata), .full(f_full), .empty(f_empty));

  txs_rate_gen #(.RATE_W(RW)) u_rate (
    .clk(clk), .rst(rst), .clear(load || flush), .tick(tick),
    .rate(cfg_q.rate), .hb_en(hb_en));

  txs_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .flush(flush), .load(load), .din(f_rdata),
    .hb_en(hb_en), .pattern(cfg_q.pattern), .busy(busy), .done(done),
    .enc_nxt(enc_nxt));

  always_ff @(posedge clk) begin
    if (rst) tx_bit <= 1'b0;
    else     tx_bit <= cfg_q.transp ? ext_bit : enc_nxt;
  end

  logic dec_net;
  assign dec_net = done && !wr_acc && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_count <= '0;
      irq_pulse  <= 1'b0;
      irq_status <= 1'b0;
      overflow   <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      irq_pulse <= dec_net && (byte_count - 1'b1 == CNT_W'(cfg_q.thr));
      if (dec_net && (byte_count - 1'b1 == CNT_W'(cfg_q.thr))) irq_status <= 1'b1;
      else if (irq_clr) irq_status <= 1'b0;
      if (flush) begin
        byte_count <= '0;
      end else if (wr_acc && !done) begin
        byte_count <= byte_count + 1'b1;
      end else if (done && !wr_acc) begin
        byte_count <= byte_count - 1'b1;
      end
      if (cfg_wr) begin
        overflow <= 1'b0;
        underrun <= 1'b0;
      end else begin
        if (wr_try && f_full)        overflow <= 1'b1;
        if (done && !load && !flush) underrun <= 1'b1;
      end
    end
  end

  p_wait_lock_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && !pll_lock) |=> state != ST_ACTIVE);
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    byte_count <= CNT_W'(DEPTH + 1));
  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(wr_en));
  p_transp_empty_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_q.transp |-> byte_count == '0);
  p_cfg_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_wr) |-> (byte_count == '0 && !overflow && !underrun));
  p_off_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFF) |-> !busy);
endmodule

// File: tb/byte_tx_serializer_bench.sv
module byte_tx_serializer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 0, cfg_wr = 0, cfg_ask = 0, cfg_pattern = 0, cfg_transp = 0;
  logic [1:0] cfg_rate = 0, cfg_thr = 0;
  logic pll_lock = 0, tick = 1, wr_en = 0, ext_bit = 0, irq_clr = 0;
  logic [7:0] wr_data = 0;
  logic tx_bit, mod_ask, irq_pulse, irq_status, overflow, underrun;
  logic [2:0] byte_count;

  int nchk = 0, nerr = 0;
  logic [7:0] pb [4];

  always #2 clk = ~clk;

  byte_tx_serializer u_byte_tx_serializer (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cfg_wr(cfg_wr), .cfg_rate(cfg_rate),
    .cfg_ask(cfg_ask), .cfg_pattern(cfg_pattern), .cfg_transp(cfg_transp),
    .cfg_thr(cfg_thr), .pll_lock(pll_lock), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .ext_bit(ext_bit), .irq_clr(irq_clr), .tx_bit(tx_bit),
    .mod_ask(mod_ask), .irq_pulse(irq_pulse), .irq_status(irq_status),
    .byte_count(byte_count), .overflow(overflow), .underrun(underrun));

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_half(logic [7:0] b, int k, bit pat);
    bit v = b[7 - (k % 16) / 2];
    return (k % 2 == 0) ? v : (pat ? v : !v);
  endfunction

  task automatic do_cfg(int r, bit ask, bit pat, bit tr, int thr);
    @(negedge clk);
    cfg_rate = 2'(r); cfg_ask = ask; cfg_pattern = pat; cfg_transp = tr;
    cfg_thr = 2'(thr); cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic write_byte(logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_pkt(int n, int r, bit pat, int thr, bit ask);
    tx_en = 0; pll_lock = 0; tick = 1;
    do_cfg(r, ask, pat, 0, thr);
    check("R11 mod_ask", mod_ask, ask);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    check("R7 irq_status cleared", irq_status, 0);
    tx_en = 1; @(negedge clk);
    for (int j = 0; j < n; j++) write_byte(pb[j]);
    check("R6 count after loads", byte_count, n);
    repeat (5) @(negedge clk);
    check("R2 idle before lock", tx_bit, 0);
    pll_lock = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    for (int k = 0; k < 16 * n; k++) begin
      if (k % 16 == 0 && k > 0) begin
        check("R6 count at byte end", byte_count, n - k / 16);
        check("R7 irq pulse", irq_pulse, (n - k / 16) == thr);
        check("R6 no underrun mid packet", underrun, 0);
      end
      check(pat ? "R4/R5 half-bit" : "R3/R5 half-bit", tx_bit,
            exp_half(pb[k / 16], k, pat));
      repeat (1 << r) @(negedge clk);
    end
    check("R6 count at end", byte_count, 0);
    check("R7 irq pulse at end", irq_pulse, thr == 0);
    check("R9 idle line", tx_bit, 0);
    check("R9 underrun", underrun, 1);
    check("R7 irq_status", irq_status, thr < n);
    @(negedge clk);
    check("R7 pulse one cycle", irq_pulse, 0);
    tx_en = 0; pll_lock = 0;
    @(negedge clk);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 tx_bit", tx_bit, 0);
    check("R1 count", byte_count, 0);
    check("R1 irq", irq_pulse | irq_status, 0);
    check("R1 flags", overflow | underrun | mod_ask, 0);

    write_byte(8'h5A);
    check("R12 write while off", byte_count, 0);

    pb[0] = 8'hA5; pb[1] = 8'h3C;
    run_pkt(2, 0, 0, 0, 1);
    pb[0] = 8'h80; pb[1] = 8'h01; pb[2] = 8'hFF; pb[3] = 8'h00;
    run_pkt(4, 1, 1, 2, 0);
    pb[0] = 8'hC3;
    run_pkt(1, 3, 0, 3, 1);

    // R8 full buffer, then R11 clear by configuration write
    do_cfg(0, 0, 0, 0, 1);
    tx_en = 1; @(negedge clk);
    for (int j = 0; j < 5; j++) write_byte(8'(j + 16));
    check("R8 count capped", byte_count, 4);
    check("R8 overflow", overflow, 1);
    do_cfg(0, 0, 0, 0, 1);
    check("R11 count cleared", byte_count, 0);
    check("R11 overflow cleared", overflow, 0);

    // R12 dropping tx_en flushes
    write_byte(8'h11); write_byte(8'h22);
    check("R12 count before drop", byte_count, 2);
    tx_en = 0; @(negedge clk);
    check("R12 count after drop", byte_count, 0);

    // R11 abort in mid-byte
    do_cfg(1, 0, 0, 0, 0);
    tx_en = 1; @(negedge clk);
    write_byte(8'hFF); write_byte(8'hFF); write_byte(8'hFF);
    pll_lock = 1; @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3 first half of 1", tx_bit, 1);
    repeat (9) @(negedge clk);
    do_cfg(1, 0, 0, 0, 0);
    check("R11 abort line", tx_bit, 0);
    check("R11 abort count", byte_count, 0);
    check("R11 no underrun", underrun, 0);
    check("R11 no irq", irq_status, 0);
    tx_en = 0; pll_lock = 0; @(negedge clk);

    // R10 transparent
    do_cfg(0, 1, 0, 1, 0);
    tx_en = 1; pll_lock = 1; @(negedge clk);
    write_byte(8'h77);
    check("R10 writes ignored", byte_count, 0);
    for (int i = 0; i < 8; i++) begin
      bit e = 1'($urandom);
      ext_bit = e; @(negedge clk);
      check("R10 follows ext_bit", tx_bit, e);
    end
    tx_en = 0; pll_lock = 0; @(negedge clk);

    // random packets
    for (int t = 0; t < 12; t++) begin
      int n = 1 + int'($urandom % 4);
      for (int j = 0; j < 4; j++) pb[j] = 8'($urandom);
      run_pkt(n, int'($urandom % 3), 1'($urandom), int'($urandom % 4), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule